// File: doc/BRIEF.md
# Ring-Oscillator Frequency-Lock Trim Controller

This block is the digital half of an on-chip clock multiplier built around a tunable ring oscillator. The oscillator has 26 delay stages. Each bit of the trim word that is 1 switches one stage into the ring, so more set bits give a slower oscillator. The controller drives that trim word and takes the oscillator's output back as a clock. It then produces the core clock.

Three operating modes are chosen by two configuration bits:
- **Off.** The trim word is forced to zero and the output clock is stopped without glitches.
- **Free-running.** A 26-bit manual word goes straight to the oscillator.
- **Frequency-locked.** The oscillator edges in each reference period are counted in the oscillator domain. The count is carried across to the reference domain as a Gray code and compared with a programmed multiplier. The loop trim is then moved by one stage, filling from bit 0 upward and saturating at both ends.

A post-divider of 1 to 7 slows the oscillator-derived clock. A bypass bit hands the core clock to the reference clock instead.

Top module: `fll_trim_ctrl`

## Requirements
- R1: While cfg_enable is 0, trim_out is all zeros, locked and saturated are 0 one reference cycle later, and with cfg_bypass 0 the core clock stays low.
- R2: With cfg_enable 1 and cfg_freerun 1, trim_out equals cfg_manual_trim bit for bit, and locked is 0.
- R3: In locked mode (cfg_enable 1, cfg_freerun 0), trim_out is always a thermometer code filled from bit 0 upward. When the measured count of oscillator rising edges per reference period is above cfg_mult, one more stage is set (the next bit above the highest 1). No decision changes the trim by more than one stage.
- R4: In locked mode, a measured count below cfg_mult clears the highest set bit, and an equal count leaves the trim unchanged. The trim settles at the stage count whose oscillator frequency is cfg_mult times the reference frequency.
- R5: When the loop asks for a further stage while all 26 bits are set, trim_out stays all ones and saturated rises. saturated then stays 1 while cfg_enable is 1, across mode changes.
- R6: When the loop asks to remove a stage while trim_out is zero, trim_out stays zero and saturated rises.
- R7: locked rises after LOCK_N consecutive equal decisions (default 4). It clears on any stage step, on any saturating request and on any mode change.
- R8: With cfg_bypass 1, core_clk follows clk_ref.
- R9: With cfg_bypass 0, core_clk carries one rising edge per N oscillator rising edges, where N is cfg_postdiv. Code 0 acts as 1.
- R10: During and right after reset, trim_out is zero, and locked and saturated are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | External reference clock; all configuration is synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_osc | input | 1 | Ring oscillator output clock |
| cfg_enable | input | 1 | 1 runs the controller and clock output; 0 stops them |
| cfg_freerun | input | 1 | 1 selects manual trim; 0 selects frequency locking |
| cfg_bypass | input | 1 | 1 routes clk_ref to core_clk |
| cfg_manual_trim | input | 26 | Stage-enable word used in free-running mode |
| cfg_mult | input | 8 | Target oscillator edges per reference period |
| cfg_postdiv | input | 3 | Output division ratio, 1 to 7 (0 treated as 1) |
| trim_out | output | 26 | Stage-enable word to the oscillator |
| core_clk | output | 1 | Selected, divided core clock |
| locked | output | 1 | Frequency lock indicator |
| saturated | output | 1 | Sticky flag: the loop ran past either end of the trim range |

## Verification
The bench places a behavioural oscillator in closed loop whose period grows with the number of set trim bits. At exactly 15 stages it gives ten edges per reference period. A controller with the step direction inverted, or without the settling wait, would run off to an end or hunt and never raise locked. Targets out of reach at both ends check that the trim clamps, rather than wrapping, and that the sticky flag survives a later successful lock. The clock tests look at division ratio 0 and the odd ratios, and at a stopped output with a ratio above 1. A divider that freezes its output high would leave the core clock stuck at 1 while disabled.

// File: rtl/fll_pkg.sv
package fll_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_FREE = 2'd1,
    MODE_LOCK = 2'd2
  } fll_mode_e;

  typedef enum logic [1:0] {
    CMP_EQ   = 2'd0,
    CMP_SLOW = 2'd1,
    CMP_FAST = 2'd2
  } fll_cmp_e;

  function automatic fll_mode_e pick_mode(input logic enable, input logic freerun);
    if (!enable)     return MODE_OFF;
    else if (freerun) return MODE_FREE;
    else             return MODE_LOCK;
  endfunction

  // Oscillator faster than target -> FAST (needs more delay stages)
  function automatic fll_cmp_e classify(input int unsigned measured, input int unsigned target);
    if (measured > target)      return CMP_FAST;
    else if (measured < target) return CMP_SLOW;
    else                        return CMP_EQ;
  endfunction

endpackage

// File: rtl/fll_edge_counter.sv
module fll_edge_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             run_req,
  output logic             run_osc,
  output logic [CNT_W-1:0] gray_cnt
);

  logic [1:0]       run_sync;
  logic [CNT_W-1:0] bin_cnt;
  logic [CNT_W-1:0] bin_nxt;

  function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) run_sync <= '0;
    else        run_sync <= {run_sync[0], run_req};
  end

  assign run_osc = run_sync[1];
  assign bin_nxt = run_osc ? bin_cnt + CNT_W'(1) : '0;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      bin_cnt  <= '0;
      gray_cnt <= '0;
    end else begin
      bin_cnt  <= bin_nxt;
      gray_cnt <= bin2gray(bin_nxt);
    end
  end

endmodule

// File: rtl/fll_count_sync.sv
module fll_count_sync #(
  parameter int CNT_W = 8
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] delta
);

  logic [CNT_W-1:0] gray_s1;
  logic [CNT_W-1:0] gray_s2;
  logic [CNT_W-1:0] prev_bin;
  logic [CNT_W-1:0] cur_bin;

  function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign cur_bin = gray2bin(gray_s2);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      gray_s1  <= '0;
      gray_s2  <= '0;
      prev_bin <= '0;
      delta    <= '0;
    end else begin
      gray_s1  <= gray_in;
      gray_s2  <= gray_s1;
      prev_bin <= cur_bin;
      delta    <= cur_bin - prev_bin;
    end
  end

endmodule

// File: rtl/fll_loop.sv
module fll_loop
  import fll_pkg::*;
#(
  parameter int TRIM_W = 26,
  parameter int CNT_W  = 8,
  parameter int MULT_W = 8,
  parameter int SETTLE = 5,
  parameter int LOCK_N = 4
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  fll_mode_e         mode,
  input  logic [MULT_W-1:0] mult,
  input  logic [CNT_W-1:0]  delta,
  output logic [TRIM_W-1:0] loop_trim,
  output logic              locked,
  output logic              saturated,
  output logic              decide,
  output logic              step_up,
  output logic              step_down,
  output logic              sat_hit
);

  localparam int HOLD_W = $clog2(SETTLE + 1);
  localparam int LCK_W  = $clog2(LOCK_N + 1);

  fll_mode_e         mode_q;
  logic              mode_chg;
  logic [HOLD_W-1:0] hold;
  logic [LCK_W-1:0]  lock_cnt;
  fll_cmp_e          verdict;
  logic              trim_full;
  logic              trim_empty;

  function automatic logic [TRIM_W-1:0] therm_up(input logic [TRIM_W-1:0] t);
    return {t[TRIM_W-2:0], 1'b1};
  endfunction

  function automatic logic [TRIM_W-1:0] therm_down(input logic [TRIM_W-1:0] t);
    return {1'b0, t[TRIM_W-1:1]};
  endfunction

  assign mode_chg   = (mode != mode_q);
  assign verdict    = classify(32'(delta), 32'(mult));
  assign trim_full  = loop_trim[TRIM_W-1];
  assign trim_empty = !loop_trim[0];
  assign decide     = (mode == MODE_LOCK) && !mode_chg && (hold == '0);
  assign step_up    = decide && (verdict == CMP_FAST) && !trim_full;
  assign step_down  = decide && (verdict == CMP_SLOW) && !trim_empty;
  assign sat_hit    = decide && (((verdict == CMP_FAST) && trim_full) ||
                                 ((verdict == CMP_SLOW) && trim_empty));

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_OFF;
      hold      <= HOLD_W'(SETTLE);
      lock_cnt  <= '0;
      loop_trim <= '0;
      locked    <= 1'b0;
      saturated <= 1'b0;
    end else if (mode == MODE_OFF) begin
      mode_q    <= MODE_OFF;
      hold      <= HOLD_W'(SETTLE);
      lock_cnt  <= '0;
      loop_trim <= '0;
      locked    <= 1'b0;
      saturated <= 1'b0;
    end else begin
      mode_q <= mode;
      if (mode_chg) begin
        hold     <= HOLD_W'(SETTLE);
        lock_cnt <= '0;
        locked   <= 1'b0;
      end else if (mode == MODE_LOCK) begin
        if (hold != '0) begin
          hold <= hold - HOLD_W'(1);
        end else begin
          if (step_up) begin
            loop_trim <= therm_up(loop_trim);
            hold      <= HOLD_W'(SETTLE - 1);
          end else if (step_down) begin
            loop_trim <= therm_down(loop_trim);
            hold      <= HOLD_W'(SETTLE - 1);
          end
          if (sat_hit) saturated <= 1'b1;
          if (verdict == CMP_EQ) begin
            if (lock_cnt != LCK_W'(LOCK_N)) lock_cnt <= lock_cnt + LCK_W'(1);
            locked <= (lock_cnt >= LCK_W'(LOCK_N - 1));
          end else begin
            lock_cnt <= '0;
            locked   <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/fll_clk_out.sv
module fll_clk_out #(
  parameter int PDIV_W = 3
) (
  input  logic              clk_osc,
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              run_osc,
  input  logic              bypass,
  input  logic [PDIV_W-1:0] pdiv,
  output logic              core_clk
);

  logic              en_lo;
  logic              gclk;
  logic [PDIV_W-1:0] ratio;
  logic [PDIV_W:0]   high_len;
  logic [PDIV_W-1:0] cnt;
  logic [PDIV_W-1:0] cnt_nxt;
  logic              div_q;
  logic              divided;

  function automatic logic [PDIV_W-1:0] eff_ratio(input logic [PDIV_W-1:0] code);
    return (code == '0) ? PDIV_W'(1) : code;
  endfunction

  function automatic logic [PDIV_W:0] high_phase(input logic [PDIV_W-1:0] r);
    return ({1'b0, r} + (PDIV_W+1)'(1)) >> 1;
  endfunction

  // enable changes only while the oscillator is low: glitch-free gate
  always_ff @(negedge clk_osc or negedge rst_n) begin
    if (!rst_n) en_lo <= 1'b0;
    else        en_lo <= run_osc;
  end

  assign gclk     = clk_osc & en_lo;
  assign ratio    = eff_ratio(pdiv);
  assign high_len = high_phase(ratio);
  assign cnt_nxt  = (cnt >= ratio - PDIV_W'(1)) ? '0 : cnt + PDIV_W'(1);

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      div_q <= ({1'b0, cnt_nxt} < high_len);
    end
  end

  assign divided  = (ratio == PDIV_W'(1)) ? gclk : (div_q & en_lo);
  assign core_clk = bypass ? clk_ref : divided;

endmodule

// File: rtl/fll_trim_ctrl.sv
module fll_trim_ctrl
  import fll_pkg::*;
#(
  parameter int TRIM_W = 26,
  parameter int CNT_W  = 8,
  parameter int MULT_W = 8,
  parameter int PDIV_W = 3,
  parameter int SETTLE = 5,
  parameter int LOCK_N = 4
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              clk_osc,
  input  logic              cfg_enable,
  input  logic              cfg_freerun,
  input  logic              cfg_bypass,
  input  logic [TRIM_W-1:0] cfg_manual_trim,
  input  logic [MULT_W-1:0] cfg_mult,
  input  logic [PDIV_W-1:0] cfg_postdiv,
  output logic [TRIM_W-1:0] trim_out,
  output logic              core_clk,
  output logic              locked,
  output logic              saturated
);

  fll_mode_e         mode;
  logic              run_osc;
  logic [CNT_W-1:0]  gray_cnt;
  logic [CNT_W-1:0]  delta;
  logic [TRIM_W-1:0] loop_trim;
  logic              decide;
  logic              step_up;
  logic              step_down;
  logic              sat_hit;

  assign mode = pick_mode(cfg_enable, cfg_freerun);

  fll_edge_counter #(.CNT_W(CNT_W)) u_edges (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .run_req  (cfg_enable),
    .run_osc  (run_osc),
    .gray_cnt (gray_cnt)
  );

  fll_count_sync #(.CNT_W(CNT_W)) u_sync (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .gray_in (gray_cnt),
    .delta   (delta)
  );

  fll_loop #(
    .TRIM_W (TRIM_W),
    .CNT_W  (CNT_W),
    .MULT_W (MULT_W),
    .SETTLE (SETTLE),
    .LOCK_N (LOCK_N)
  ) u_loop (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .mode      (mode),
    .mult      (cfg_mult),
    .delta     (delta),
    .loop_trim (loop_trim),
    .locked    (locked),
    .saturated (saturated),
    .decide    (decide),
    .step_up   (step_up),
    .step_down (step_down),
    .sat_hit   (sat_hit)
  );

  always_comb begin
    unique case (mode)
      MODE_FREE: trim_out = cfg_manual_trim;
      MODE_LOCK: trim_out = loop_trim;
      default:   trim_out = '0;
    endcase
  end

  fll_clk_out #(.PDIV_W(PDIV_W)) u_clkout (
    .clk_osc  (clk_osc),
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .run_osc  (run_osc),
    .bypass   (cfg_bypass),
    .pdiv     (cfg_postdiv),
    .core_clk (core_clk)
  );

endmodule

// File: rtl/fll_trim_chk.sv
module fll_trim_chk
  import fll_pkg::*;
#(
  parameter int TRIM_W = 26
) (
  input logic              clk_ref,
  input logic              rst_n,
  input logic              cfg_enable,
  input fll_mode_e         mode,
  input logic [TRIM_W-1:0] trim_out,
  input logic              locked,
  input logic              saturated,
  input logic              decide,
  input logic              step_up,
  input logic              step_down,
  input logic              sat_hit
);

  AST_OFF_CLEARS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !cfg_enable |=> (trim_out == '0 && !locked && !saturated)); // R1

  AST_FREE_NO_LOCK: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == MODE_FREE) |=> !locked); // R2

  AST_THERMO_FORM: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == MODE_LOCK) |-> ((trim_out & (trim_out + TRIM_W'(1))) == '0)); // R3

  AST_ONE_STAGE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == MODE_LOCK && $past(mode) == MODE_LOCK) |-> ($countones(trim_out ^ $past(trim_out)) <= 1)); // R3

  AST_UP_ADDS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    step_up |=> (mode != MODE_LOCK || $countones(trim_out) == $countones($past(trim_out)) + 1)); // R3

  AST_DOWN_REMOVES: assert property (@(posedge clk_ref) disable iff (!rst_n)
    step_down |=> (mode != MODE_LOCK || $countones(trim_out) + 1 == $countones($past(trim_out)))); // R4

  AST_STEP_EXCL: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $countones({step_up, step_down, sat_hit}) <= 1 && (!(step_up || step_down || sat_hit) || decide)); // R4

  AST_SAT_SETS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sat_hit |=> saturated); // R5

  AST_SAT_STICKY: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (saturated && cfg_enable) |=> saturated); // R5

  AST_SAT_HOLDS_END: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sat_hit |=> (mode != MODE_LOCK || $stable(trim_out))); // R6

  AST_LOCK_DROP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (step_up || step_down || sat_hit) |=> !locked); // R7

endmodule

bind fll_trim_ctrl fll_trim_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .mode       (mode),
  .trim_out   (trim_out),
  .locked     (locked),
  .saturated  (saturated),
  .decide     (decide),
  .step_up    (step_up),
  .step_down  (step_down),
  .sat_hit    (sat_hit)
);

// File: tb/sim_fll_trim_ctrl.sv
`timescale 1ns/1ps
module sim_fll_trim_ctrl;

  typedef struct {
    string rq;
    int    fld;   // 0 trim, 1 locked, 2 saturated
    int    exp;
  } exp_t;

  logic        clk_ref = 1'b0;
  logic        rst_n   = 1'b0;
  logic        osc_clk = 1'b0;
  logic        cfg_enable = 1'b1;
  logic        cfg_freerun = 1'b0;
  logic        cfg_bypass = 1'b0;
  logic [25:0] cfg_manual_trim = '0;
  logic [7:0]  cfg_mult = 8'd10;
  logic [2:0]  cfg_postdiv = 3'd1;
  logic [25:0] trim_out;
  logic        core_clk;
  logic        locked;
  logic        saturated;

  int   checks = 0;
  int   fails  = 0;
  int   osc_edges = 0;
  int   core_edges = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];
  event sample_ev;

  fll_trim_ctrl u0 (
    .clk_ref         (clk_ref),
    .rst_n           (rst_n),
    .clk_osc         (osc_clk),
    .cfg_enable      (cfg_enable),
    .cfg_freerun     (cfg_freerun),
    .cfg_bypass      (cfg_bypass),
    .cfg_manual_trim (cfg_manual_trim),
    .cfg_mult        (cfg_mult),
    .cfg_postdiv     (cfg_postdiv),
    .trim_out        (trim_out),
    .core_clk        (core_clk),
    .locked          (locked),
    .saturated       (saturated)
  );

  always #10 clk_ref = ~clk_ref;   // 50 MHz reference

  // Ring oscillator model: 0.5 ns base period plus 0.1 ns per enabled stage
  function automatic real osc_half_ns();
    return 0.25 + 0.05 * $countones(trim_out);
  endfunction

  initial begin
    #0.33;
    forever begin
      #(osc_half_ns());
      osc_clk = ~osc_clk;
    end
  end

  always @(posedge osc_clk)  osc_edges++;
  always @(posedge core_clk) core_edges++;

  task automatic chk(input string rq, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", rq, got, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_state(input string rq, input int t, input int lk, input int st);
    exp_t it;
    it.rq = rq; it.fld = 0; it.exp = t;  sb_q.push_back(it);
    it.fld = 1; it.exp = lk; sb_q.push_back(it);
    it.fld = 2; it.exp = st; sb_q.push_back(it);
    -> sample_ev;
    wait (sb_q.size() == 0);
  endtask

  // monitor side
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        exp_t it;
        int   got;
        it = sb_q.pop_front();
        case (it.fld)
          0:       got = int'(trim_out);
          1:       got = int'(locked);
          default: got = int'(saturated);
        endcase
        chk(it.rq, got, it.exp);
      end
    end
  end

  task automatic wait_ref(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic measure_div(input int code, input string rq);
    int o0, c0, dosc, dcore, ratio, expc, diff;
    cfg_postdiv = 3'(code);
    wait_ref(10);
    o0 = osc_edges;
    c0 = core_edges;
    wait_ref(100);
    dosc  = osc_edges - o0;
    dcore = core_edges - c0;
    ratio = (code == 0) ? 1 : code;
    expc  = dosc / ratio;
    diff  = dcore - expc;
    if (diff < 0) diff = -diff;
    chk(rq, (diff <= 1) ? expc : dcore, expc);
  endtask

  initial begin
    int t;
    int highs;
    // R10: reset state
    wait_ref(3);
    expect_state("R10 reset", 0, 0, 0);
    rst_n = 1'b1;
    wait_ref(1);
    expect_state("R10 after reset", 0, 0, 0);

    // R3: loop climbs in thermometer steps toward 15 stages
    wait_ref(25);
    t = int'(trim_out);
    chk("R3 thermometer climb", ((t & (t + 1)) == 0 && t != 0 && $countones(t) < 15) ? 1 : 0, 1);

    // R4 / R7: settle at 15 stages (10 edges per reference period) and lock
    wait_ref(400);
    expect_state("R4 R7 lock at 10x", 26'h0007FFF, 1, 0);

    // R2: free-running manual word; lock drops on mode change (R7)
    cfg_freerun     = 1'b1;
    cfg_manual_trim = 26'h2A55A5A;
    wait_ref(1);
    expect_state("R2 R7 manual trim", 26'h2A55A5A, 0, 0);

    // R9: post-divider ratios with a 10-stage manual word
    cfg_manual_trim = 26'h00003FF;
    measure_div(1, "R9 divide by 1");
    measure_div(3, "R9 divide by 3");
    measure_div(7, "R9 divide by 7");
    measure_div(0, "R9 code 0 acts as 1");
    measure_div(2, "R9 divide by 2");

    // R8: bypass follows reference
    cfg_bypass = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_ref); #5;
      chk("R8 bypass high phase", int'(core_clk), 1);
      @(negedge clk_ref); #5;
      chk("R8 bypass low phase", int'(core_clk), 0);
    end
    cfg_bypass = 1'b0;

    // R5: unreachable slow target saturates at all ones
    wait_ref(1);
    cfg_mult    = 8'd2;
    cfg_freerun = 1'b0;
    wait_ref(600);
    expect_state("R5 saturate high", 26'h3FFFFFF, 0, 1);

    // R1: disable clears everything and stops the clock (divider 3 path)
    cfg_postdiv = 3'd3;
    cfg_enable  = 1'b0;
    wait_ref(5);
    expect_state("R1 disabled", 0, 0, 0);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      #0.7;
      if (core_clk) highs++;
    end
    chk("R1 core clock stopped", highs, 0);

    // R6: unreachable fast target saturates at zero
    @(negedge clk_ref);
    cfg_mult   = 8'd60;
    cfg_enable = 1'b1;
    wait_ref(400);
    expect_state("R6 saturate low", 0, 0, 1);

    // R5 sticky across a successful lock, then R7 clears on mode change
    cfg_mult = 8'd10;
    wait_ref(500);
    expect_state("R5 sticky while locked", 26'h0007FFF, 1, 1);
    cfg_freerun = 1'b1;
    wait_ref(1);
    chk("R7 mode change clears lock", int'(locked), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule